// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a non-volatile byte memory. It reports the progress of an internal program or erase operation through the ordinary read data. A one-cycle start pulse launches an operation. The pulse carries the operation type and the byte being written. The block then runs a busy timer for the cycle count that belongs to that operation type. While the timer runs, two bits of every registered read are replaced by status bits:

- Bit 7 is a polarity flag. Its meaning depends on the operation.
- Bit 6 flips on every read.

Once the operation ends, bit 7 shows true data straight away. Bit 6 keeps its last status value until a short settling window has passed. After that window, the whole array byte is passed through.

A host finds out that the operation has finished in one of two ways. It can compare bit 7 of a read with the value it expects. It can also read twice and check whether bit 6 stopped changing. All durations are parameters counted in clock cycles, so a fast simulation can shrink them.

Top module: `wcs_reporter`

## Requirements
- R1: After synchronous reset, `busy_o` is 0 and `rdata_o` is 8'h00.
- R2: An accepted start raises `busy_o` from the next cycle for exactly the operation's cycle count. Operation code 2'b00 (program) uses PROG_CYC, 2'b01 (sector erase) uses SECT_CYC, and 2'b10 or 2'b11 (chip erase) use CHIP_CYC.
- R3: A read while a program is busy returns bit 7 as the complement of bit 7 of the byte latched at start.
- R4: A read while an erase is busy returns bit 7 as 0.
- R5: The start of each operation sets the toggle bit to 1. Each read while busy returns the toggle bit in bit 6 and then inverts it, so the first read returns 1 and later reads alternate.
- R6: A read while busy or settling returns `array_i[5:0]` in bits 5:0.
- R7: For SETTLE_CYC cycles after busy ends, a read returns the true `array_i[7]` in bit 7. Bit 6 holds the last toggle value, and reads no longer change it.
- R8: A read while neither busy nor settling returns `array_i` unchanged.
- R9: A start while busy is ignored: the running operation keeps its type, its latched byte and its end time.
- R10: `rdata_o` changes only at a clock edge where `rd_i` is 1, and holds its value otherwise.
- R11: A read in the same cycle as an accepted start sees the state before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle launch of an internal operation |
| op_i | input | 2 | Operation type: 00 program, 01 sector erase, 1x chip erase |
| wdata_i | input | 8 | Byte being programmed; bit 7 sets the polarity flag |
| rd_i | input | 1 | Read strobe |
| array_i | input | 8 | Array data for the addressed byte |
| rdata_o | output | 8 | Registered read byte |
| busy_o | output | 1 | Internal operation in progress |

## Verification
The bench goes after three kinds of corner case.

- **Read on the launch edge.** A design that let the start leak into the same read would return a status byte instead of array data.
- **A second start while busy.** A design that accepted it would restart the timer or switch to the erase polarity, and busy would last the chip-erase count instead of the program count.
- **The toggle sequence.** The bench reads back to back and also leaves idle gaps between reads. A design that flipped bit 6 per clock, or failed to preset it, would give a first read of 0 or the wrong alternation.

The settling window is also probed. A design that resumed toggling, or dropped straight to raw data, would show up there. The bench also checks the exact busy length of all four operation codes.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_SECT  = 2'b01,
    OP_CHIP  = 2'b10,
    OP_CHIPX = 2'b11
  } op_e;

  // polarity flag shown in bit 7 while an operation runs
  function automatic logic poll_bit(input logic [1:0] op, input logic d7);
    return (op == OP_PROG) ? ~d7 : 1'b0;
  endfunction

  // status byte while busy: flag, toggle, then low array bits
  function automatic logic [7:0] busy_byte(input logic flag, input logic tog,
                                           input logic [7:0] arr);
    return {flag, tog, arr[5:0]};
  endfunction

  // byte while settling: true top bit, frozen toggle, low array bits
  function automatic logic [7:0] settle_byte(input logic tog, input logic [7:0] arr);
    return {arr[7], tog, arr[5:0]};
  endfunction

endpackage

// File: rtl/wcs_busy_timer.sv
module wcs_busy_timer #(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy_o,
  output logic             settle_o,
  output logic             done_o
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= dur_i - 1'b1;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q - 1'b1;
    end
  end

  generate
    if (SETTLE_CYC > 0) begin : g_settle
      logic          set_q;
      logic [SW-1:0] scnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          set_q  <= 1'b0;
          scnt_q <= '0;
        end else if (load_i) begin
          set_q  <= 1'b0;
        end else if (done_o) begin
          set_q  <= 1'b1;
          scnt_q <= SW'(SETTLE_CYC - 1);
        end else if (set_q) begin
          if (scnt_q == '0) set_q  <= 1'b0;
          else              scnt_q <= scnt_q - 1'b1;
        end
      end
      assign settle_o = set_q;
    end else begin : g_nosettle
      assign settle_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic step_i,
  output logic tog_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)         tog_o <= 1'b1;
    else if (restart_i) tog_o <= 1'b1;
    else if (step_i)    tog_o <= ~tog_o;
  end
endmodule

// File: rtl/wcs_read_mux.sv
module wcs_read_mux
  import wcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_i,
  input  logic       busy_i,
  input  logic       settle_i,
  input  logic       flag_i,
  input  logic       tog_i,
  input  logic [7:0] array_i,
  output logic [7:0] rdata_o
);
  logic [7:0] next_byte;

  always_comb begin
    if (busy_i)        next_byte = busy_byte(flag_i, tog_i, array_i);
    else if (settle_i) next_byte = settle_byte(tog_i, array_i);
    else               next_byte = array_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_o <= 8'h00;
    else if (rd_i) rdata_o <= next_byte;
  end
endmodule

// File: rtl/wcs_reporter.sv
module wcs_reporter
  import wcs_pkg::*;
#(
  parameter int PROG_CYC   = 1000,
  parameter int SECT_CYC   = 1250000,
  parameter int CHIP_CYC   = 5000000,
  parameter int SETTLE_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  input  logic [7:0] array_i,
  output logic [7:0] rdata_o,
  output logic       busy_o
);
  localparam int MAX_ER  = (SECT_CYC > CHIP_CYC) ? SECT_CYC : CHIP_CYC;
  localparam int MAX_CYC = (PROG_CYC > MAX_ER) ? PROG_CYC : MAX_ER;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] D_PROG = CNT_W'(PROG_CYC);
  localparam logic [CNT_W-1:0] D_SECT = CNT_W'(SECT_CYC);
  localparam logic [CNT_W-1:0] D_CHIP = CNT_W'(CHIP_CYC);

  // named events for the checker
  logic             accept_start;
  logic             read_step;
  logic [1:0]       run_op;
  logic             run_d7;
  logic             settle;
  logic             tog_q;
  logic             op_done;
  logic [CNT_W-1:0] dur_sel;
  wire              unused_wdata = ^wdata_i[6:0];

  assign accept_start = start_i && !busy_o;
  assign read_step    = rd_i && busy_o;

  always_comb begin
    case (op_i)
      OP_PROG: dur_sel = D_PROG;
      OP_SECT: dur_sel = D_SECT;
      default: dur_sel = D_CHIP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_op <= OP_PROG;
      run_d7 <= 1'b0;
    end else if (accept_start) begin
      run_op <= op_i;
      run_d7 <= wdata_i[7];
    end
  end

  wcs_busy_timer #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept_start),
    .dur_i    (dur_sel),
    .busy_o   (busy_o),
    .settle_o (settle),
    .done_o   (op_done)
  );

  wcs_toggle u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept_start),
    .step_i    (read_step),
    .tog_o     (tog_q)
  );

  wcs_read_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd_i),
    .busy_i   (busy_o),
    .settle_i (settle),
    .flag_i   (poll_bit(run_op, run_d7)),
    .tog_i    (tog_q),
    .array_i  (array_i),
    .rdata_o  (rdata_o)
  );

endmodule

// File: rtl/wcs_checker.sv
module wcs_checker
  import wcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rd_i,
  input logic [7:0] array_i,
  input logic [7:0] rdata_o,
  input logic       busy_o,
  input logic       settle,
  input logic       tog_q,
  input logic [1:0] run_op,
  input logic       run_d7
);
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_prog_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_o && run_op == OP_PROG) |=> rdata_o[7] == ~$past(run_d7));

  assert_erase_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_o && run_op != OP_PROG) |=> rdata_o[7] == 1'b0);

  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_o) |=> (tog_q != $past(tog_q)) && (rdata_o[6] == $past(tog_q)));

  assert_toggle_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> tog_q);

  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (busy_o || settle)) |=> rdata_o[5:0] == $past(array_i[5:0]));

  assert_settle_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && settle && !busy_o && !start_i) |=>
      (rdata_o[7] == $past(array_i[7])) && $stable(tog_q));

  assert_idle_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !busy_o && !settle) |=> rdata_o == $past(array_i));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> $stable(run_op) && $stable(run_d7));

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

bind wcs_reporter wcs_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .rd_i    (rd_i),
  .array_i (array_i),
  .rdata_o (rdata_o),
  .busy_o  (busy_o),
  .settle  (settle),
  .tog_q   (tog_q),
  .run_op  (run_op),
  .run_d7  (run_d7)
);

// File: tb/tb_wcs_reporter.sv
module tb_wcs_reporter;
  localparam int CLK_P  = 10;
  localparam int P_PROG = 7;
  localparam int P_SECT = 13;
  localparam int P_CHIP = 21;
  localparam int P_SET  = 4;

  logic       clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, rd_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] wdata_i = 8'h00, array_i = 8'h00;
  wire  [7:0] rdata_o;
  wire        busy_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done_flag = 0;

  wcs_reporter #(.PROG_CYC(P_PROG), .SECT_CYC(P_SECT), .CHIP_CYC(P_CHIP),
                 .SETTLE_CYC(P_SET)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .array_i(array_i),
    .rdata_o(rdata_o), .busy_o(busy_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         b_left, s_left;
  bit         m_tog, m_on;
  logic [1:0] m_op;
  logic [7:0] m_wd, m_rd;
  string      m_tag;

  function automatic int dur_of(input logic [1:0] op);
    if (op == 2'b00) return P_PROG;
    if (op == 2'b01) return P_SECT;
    return P_CHIP;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      b_left = 0; s_left = 0; m_tog = 1; m_rd = 8'h00; m_tag = "R1";
      m_op = 2'b00; m_wd = 8'h00;
    end else begin
      bit was_busy;
      was_busy = (b_left > 0);
      if (rd_i) begin
        if (was_busy) begin
          m_rd  = {(m_op == 2'b00) ? ~m_wd[7] : 1'b0, m_tog, array_i[5:0]};
          m_tag = (m_op == 2'b00) ? "R3" : "R4";
        end else if (s_left > 0) begin
          m_rd  = {array_i[7], m_tog, array_i[5:0]};
          m_tag = "R7";
        end else begin
          m_rd  = array_i;
          m_tag = "R8";
        end
      end else m_tag = "R10";
      if (was_busy) begin
        if (rd_i) m_tog = ~m_tog;
        b_left--;
        if (b_left == 0) s_left = P_SET;
      end else if (s_left > 0) s_left--;
      if (start_i && !was_busy) begin
        b_left = dur_of(op_i); s_left = 0; m_tog = 1;
        m_op = op_i; m_wd = wdata_i;
      end
    end
  end

  always @(negedge clk) begin
    if (m_on && !done_flag) begin
      chk(rdata_o == m_rd, m_tag, rdata_o, m_rd);
      chk(busy_o == (b_left > 0), "R2", busy_o, b_left > 0);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog actual %0d expected below %0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic do_read(input logic [7:0] arr, output logic [7:0] got);
    @(negedge clk); rd_i = 1; array_i = arr;
    @(negedge clk); rd_i = 0; got = rdata_o;
  endtask

  task automatic do_start(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk); start_i = 1; op_i = op; wdata_i = d;
    @(negedge clk); start_i = 0;
  endtask

  task automatic measure(input logic [1:0] op, input int exp, input string tag);
    int n;
    n = 0;
    @(negedge clk); start_i = 1; op_i = op;
    @(negedge clk); start_i = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic wait_idle();
    repeat (P_CHIP + P_SET + 3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] got;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(busy_o == 1'b0 && rdata_o == 8'h00, "R1", {busy_o, rdata_o}, 0);
    m_on = 1;

    // idle pass-through
    do_read(8'hC3, got);
    chk(got == 8'hC3, "R8", got, 8'hC3);

    // read on the launch edge sees the pre-start state
    @(negedge clk); start_i = 1; op_i = 2'b00; wdata_i = 8'h35; rd_i = 1; array_i = 8'h11;
    @(negedge clk); start_i = 0; rd_i = 0;
    chk(rdata_o == 8'h11, "R11", rdata_o, 8'h11);

    // program reads: flag = ~0 = 1, toggle 1,0,1, low bits 0x2A
    do_read(8'h2A, got);
    chk(got == 8'hEA, "R5", got, 8'hEA);
    chk(got[5:0] == 6'h2A, "R6", got[5:0], 6'h2A);
    @(negedge clk); rd_i = 1; array_i = 8'h2A;
    @(negedge clk);
    chk(rdata_o == 8'hAA, "R5", rdata_o, 8'hAA);
    @(negedge clk); rd_i = 0;
    chk(rdata_o == 8'hEA, "R3", rdata_o, 8'hEA);

    // settle: bit7 true, toggle frozen at 0 after three reads
    while (busy_o) @(negedge clk);
    do_read(8'h95, got);
    chk(got == 8'h95, "R7", got, 8'h95);
    do_read(8'h15, got);
    chk(got == 8'h15, "R7", got, 8'h15);
    wait_idle();

    // program with bit7 set: flag reads 0
    do_start(2'b00, 8'hA0);
    do_read(8'hFF, got);
    chk(got == 8'h7F, "R3", got, 8'h7F);
    wait_idle();

    // erase flags, odd read gaps
    do_start(2'b01, 8'hFF);
    do_read(8'hFF, got);
    chk(got == 8'h7F, "R4", got, 8'h7F);
    repeat (2) @(negedge clk);
    do_read(8'hFF, got);
    chk(got == 8'h3F, "R5", got, 8'h3F);
    wait_idle();

    // ignored second start: busy keeps the program length
    n = 0;
    @(negedge clk); start_i = 1; op_i = 2'b00; wdata_i = 8'h00;
    @(negedge clk); op_i = 2'b10; wdata_i = 8'h80; if (busy_o) n++;
    @(negedge clk); start_i = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    chk(n == P_PROG, "R9", n, P_PROG);
    wait_idle();

    // busy lengths per code
    measure(2'b00, P_PROG, "R2");  wait_idle();
    measure(2'b01, P_SECT, "R2");  wait_idle();
    measure(2'b10, P_CHIP, "R2");  wait_idle();
    measure(2'b11, P_CHIP, "R2");  wait_idle();

    // hold without read while array changes
    do_read(8'h5A, got);
    @(negedge clk); array_i = 8'hA5;
    @(negedge clk);
    chk(rdata_o == 8'h5A, "R10", rdata_o, 8'h5A);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule